// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns a 32-bit virtual address for an instruction fetch, a load or a store into a physical address and a memory access type. It also runs the access checks that go with the translation. Each request is presented for one cycle with `req_valid`. One cycle later the block returns a registered response: either a physical address with its memory type, or a 6-bit exception code together with the faulting virtual address.

The checks run in a fixed order, and the first one that decides ends the chain:
1. alignment against the access size;
2. the paging-off bypass;
3. two direct-map windows;
4. the user-space upper bound;
5. a fully associative lookup in a small TLB of paired even/odd pages, where each entry is either a 4 KiB or a 2 MiB page;
6. the valid, privilege and dirty checks on the selected half of the pair.

The TLB contents reach the block as one flat read bus, with entry 0 in the least significant bits. Writing to the TLB is done elsewhere.

Top module: `vat_xlate`

## Requirements
- R1: The block answers every cycle in which `req_valid` is high by raising `rsp_valid` in the following cycle, and in no other cycle. Synchronous reset clears every output to zero.
- R2: Alignment depends on the access size:
  - `req_size` 0 is a byte and is never misaligned;
  - `req_size` 1 is a halfword and is misaligned when address bit 0 is set;
  - `req_size` 2 or 3 is a word and is misaligned when either of address bits 1:0 is set.
  
  A misaligned fetch (`req_kind` 0) gives code 8. A misaligned load (`req_kind` 1) or store (`req_kind` 2) gives code 10. This check runs before any other.
- R3: With `paging_on` low, the physical address equals the virtual address. The memory type is `fetch_mat` for a fetch and `data_mat` for a load or store. No bound or TLB check applies.
- R4: Window configuration layout is: bit 0 enables the window at level 0, bit 1 enables it at level 3, bits 3:2 hold the memory type, bits 6:4 the physical segment, and bits 9:7 the virtual segment.
  - A window hits when address bits 31:29 equal its virtual segment and it is enabled for the current level. Levels 1 and 2 never hit a window.
  - On a hit, the physical address is the physical segment followed by address bits 28:0, and the memory type is the window's own.
  - Window 0 is checked before window 1.
- R5: With paging on and no window hit, a level-3 access at or above 0x80000000 gives code 8 for a fetch and code 9 otherwise. At level 0 such an address goes on to the TLB.
- R6: TLB entries are 84 bits wide. From the most significant bit down, an entry holds:
  - E (1 bit);
  - G (1 bit);
  - a large-page flag (1 bit; set means page-size bit 21, clear means bit 12);
  - ASID (10 bits);
  - VPPN (19 bits);
  - the odd half (26 bits);
  - the even half (26 bits).
  
  Each half holds, from its most significant bit down, V, D, PLV (2 bits), memory type (2 bits) and PPN (20 bits). An entry matches when E is 1, G is 1 or its ASID equals `cur_asid`, and the address bits above the page-size bit equal the corresponding upper VPPN bits.
- R7: The page-size bit of the address selects the half: 0 selects the even half, 1 the odd half. The physical address is the PPN bits above the page-size bit followed by the address bits below it. The memory type is the half's own.
- R8: When no entry matches, the code is 63.
- R9: A selected half with V=0 gives code 3 for a fetch, 1 for a load and 2 for a store.
- R10: A valid half whose PLV is numerically below `cur_plv` gives code 7.
- R11: A store to a valid half with D=0 gives code 4. The privilege check comes before this one.
- R12: When several entries match, the one with the lowest index is used.
- R13: A response with a non-zero code has `pa_valid` low, `pa` and `pa_mat` zero, and `bad_va` equal to the request address. A successful response has `pa_valid` high, code 0 and `bad_va` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_va | input | 32 | Virtual address |
| cur_plv | input | 2 | Current privilege level |
| paging_on | input | 1 | Mapped translation enable |
| cur_asid | input | 10 | Current address-space identifier |
| fetch_mat | input | 2 | Memory type for fetches with paging off |
| data_mat | input | 2 | Memory type for data with paging off |
| win0_cfg | input | 10 | Direct-map window 0 configuration |
| win1_cfg | input | 10 | Direct-map window 1 configuration |
| tlb_flat | input | TLB_DEPTH*84 | TLB contents, entry 0 in the low bits |
| rsp_valid | output | 1 | Response strobe |
| pa_valid | output | 1 | Translation succeeded |
| pa | output | 32 | Physical address |
| pa_mat | output | 2 | Memory access type |
| exc_code | output | 6 | Exception code, 0 when none |
| bad_va | output | 32 | Faulting virtual address |

## Verification
Every result of this block (the physical address, memory type, code, faulting address and both valid flags) is due exactly one rising edge after the request. Nothing is due in the cycle of the request itself or two cycles later. The bench drives each request on a falling edge, lets a single rising edge pass, and compares all six outputs on the next falling edge. It then drops `req_valid` so that the following cycle must show `rsp_valid` low. The reset and idle tests sample at the same one-edge offset.

// File: rtl/vat_pkg.sv
package vat_pkg;

    localparam int VA_W    = 32;
    localparam int ASID_W  = 10;
    localparam int PPN_W   = 20;
    localparam int VPPN_W  = 19;
    localparam int NWIN    = 2;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [5:0] {
        EC_NONE    = 6'd0,
        EC_PG_LD   = 6'd1,
        EC_PG_ST   = 6'd2,
        EC_PG_IF   = 6'd3,
        EC_DIRTY   = 6'd4,
        EC_PRIV    = 6'd7,
        EC_ADR_IF  = 6'd8,
        EC_ADR_MEM = 6'd9,
        EC_ALIGN   = 6'd10,
        EC_REFILL  = 6'd63
    } exc_e;

    typedef struct packed {
        logic             v;
        logic             d;
        logic [1:0]       plv;
        logic [1:0]       mat;
        logic [PPN_W-1:0] ppn;
    } half_t;

    typedef struct packed {
        logic              e;
        logic              g;
        logic              big;
        logic [ASID_W-1:0] asid;
        logic [VPPN_W-1:0] vppn;
        half_t             odd;
        half_t             even;
    } tlb_ent_t;

    localparam int ENT_W = $bits(tlb_ent_t);

    typedef struct packed {
        logic [2:0] vseg;
        logic [2:0] pseg;
        logic [1:0] mat;
        logic       u_en;
        logic       k_en;
    } dmw_t;

    localparam int DMW_W = $bits(dmw_t);

    function automatic logic misaligned(input logic [1:0] size, input logic [1:0] lo);
        case (size)
            2'd0:    return 1'b0;
            2'd1:    return lo[0];
            default: return |lo;
        endcase
    endfunction

endpackage

// File: rtl/vat_dmw_match.sv
module vat_dmw_match
    import vat_pkg::*;
#(
    parameter int N = NWIN
) (
    input  dmw_t       wins [N],
    input  logic [2:0] va_seg,
    input  logic [1:0] plv,
    output logic       hit,
    output logic [2:0] pseg,
    output logic [1:0] mat
);

    logic [N-1:0] w_hit;

    for (genvar i = 0; i < N; i++) begin : g_win
        logic lvl_ok;
        assign lvl_ok   = (plv == 2'd0 && wins[i].k_en) || (plv == 2'd3 && wins[i].u_en);
        assign w_hit[i] = lvl_ok && (wins[i].vseg == va_seg);
    end

    // lowest numbered window takes precedence
    always_comb begin
        pseg = '0;
        mat  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (w_hit[i]) begin
                pseg = wins[i].pseg;
                mat  = wins[i].mat;
            end
        end
    end

    assign hit = |w_hit;

endmodule

// File: rtl/vat_tlb_lookup.sv
module vat_tlb_lookup
    import vat_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  tlb_ent_t          ents [DEPTH],
    input  logic [VA_W-1:12]  va_hi,
    input  logic [ASID_W-1:0] asid,
    output logic              found,
    output logic              big,
    output half_t             sel
);

    logic [DEPTH-1:0] match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic id_ok, tag_ok;
        assign id_ok  = ents[i].g || (ents[i].asid == asid);
        assign tag_ok = ents[i].big ? (ents[i].vppn[VPPN_W-1:9] == va_hi[31:22])
                                    : (ents[i].vppn == va_hi[31:13]);
        assign match[i] = ents[i].e && id_ok && tag_ok;
    end

    // scan from the top so the lowest matching index is left standing
    always_comb begin
        sel = '0;
        big = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                big = ents[i].big;
                sel = (ents[i].big ? va_hi[21] : va_hi[12]) ? ents[i].odd : ents[i].even;
            end
        end
    end

    assign found = |match;

endmodule

// File: rtl/vat_xlate.sv
module vat_xlate
    import vat_pkg::*;
#(
    parameter int TLB_DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [1:0]                 req_kind,
    input  logic [1:0]                 req_size,
    input  logic [31:0]                req_va,
    input  logic [1:0]                 cur_plv,
    input  logic                       paging_on,
    input  logic [9:0]                 cur_asid,
    input  logic [1:0]                 fetch_mat,
    input  logic [1:0]                 data_mat,
    input  logic [9:0]                 win0_cfg,
    input  logic [9:0]                 win1_cfg,
    input  logic [TLB_DEPTH*84-1:0]    tlb_flat,
    output logic                       rsp_valid,
    output logic                       pa_valid,
    output logic [31:0]                pa,
    output logic [1:0]                 pa_mat,
    output logic [5:0]                 exc_code,
    output logic [31:0]                bad_va
);

    dmw_t     wins [NWIN];
    tlb_ent_t ents [TLB_DEPTH];

    assign wins[0] = dmw_t'(win0_cfg);
    assign wins[1] = dmw_t'(win1_cfg);

    for (genvar i = 0; i < TLB_DEPTH; i++) begin : g_unpack
        assign ents[i] = tlb_ent_t'(tlb_flat[i*ENT_W +: ENT_W]);
    end

    logic       win_hit;
    logic [2:0] win_pseg;
    logic [1:0] win_mat;

    vat_dmw_match #(.N(NWIN)) i_dmw (
        .wins   (wins),
        .va_seg (req_va[31:29]),
        .plv    (cur_plv),
        .hit    (win_hit),
        .pseg   (win_pseg),
        .mat    (win_mat)
    );

    logic  tlb_found, tlb_big;
    half_t tlb_sel;

    vat_tlb_lookup #(.DEPTH(TLB_DEPTH)) i_tlb (
        .ents  (ents),
        .va_hi (req_va[31:12]),
        .asid  (cur_asid),
        .found (tlb_found),
        .big   (tlb_big),
        .sel   (tlb_sel)
    );

    acc_e        kind;
    logic        is_fetch, is_store, bad_align;
    exc_e        nx_ec;
    logic [31:0] nx_pa;
    logic [1:0]  nx_mat;

    assign kind      = acc_e'(req_kind);
    assign is_fetch  = (kind == ACC_FETCH);
    assign is_store  = (kind == ACC_STORE);
    assign bad_align = misaligned(req_size, req_va[1:0]);

    always_comb begin
        nx_ec  = EC_NONE;
        nx_pa  = req_va;
        nx_mat = is_fetch ? fetch_mat : data_mat;
        if (bad_align) begin
            nx_ec = is_fetch ? EC_ADR_IF : EC_ALIGN;
        end else if (!paging_on) begin
            nx_pa = req_va;
        end else if (win_hit) begin
            nx_pa  = {win_pseg, req_va[28:0]};
            nx_mat = win_mat;
        end else if (cur_plv == 2'd3 && req_va[31]) begin
            nx_ec = is_fetch ? EC_ADR_IF : EC_ADR_MEM;
        end else if (!tlb_found) begin
            nx_ec = EC_REFILL;
        end else if (!tlb_sel.v) begin
            nx_ec = is_fetch ? EC_PG_IF : (is_store ? EC_PG_ST : EC_PG_LD);
        end else if (cur_plv > tlb_sel.plv) begin
            nx_ec = EC_PRIV;
        end else if (is_store && !tlb_sel.d) begin
            nx_ec = EC_DIRTY;
        end else begin
            nx_pa  = tlb_big ? {tlb_sel.ppn[PPN_W-1:9], req_va[20:0]}
                             : {tlb_sel.ppn, req_va[11:0]};
            nx_mat = tlb_sel.mat;
        end
    end

    logic ok;
    assign ok = (nx_ec == EC_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            pa_valid  <= 1'b0;
            pa        <= '0;
            pa_mat    <= '0;
            exc_code  <= '0;
            bad_va    <= '0;
        end else begin
            rsp_valid <= req_valid;
            pa_valid  <= req_valid && ok;
            pa        <= (req_valid && ok) ? nx_pa : '0;
            pa_mat    <= (req_valid && ok) ? nx_mat : '0;
            exc_code  <= req_valid ? nx_ec : EC_NONE;
            bad_va    <= (req_valid && !ok) ? req_va : '0;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                                          // R1
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);                                                        // R1
    AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (rst)
        req_valid && misaligned(req_size, req_va[1:0]) |=>
            (exc_code == EC_ALIGN || exc_code == EC_ADR_IF));                              // R2
    AST_USER_BOUND: assert property (@(posedge clk) disable iff (rst)
        req_valid && paging_on && cur_plv == 2'd3 && req_va[31] && !win_hit |=> !pa_valid); // R5
    AST_PA_EXCL: assert property (@(posedge clk) disable iff (rst)
        pa_valid |-> (rsp_valid && exc_code == EC_NONE));                                  // R13
    AST_BADV_ON_EXC: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && exc_code != EC_NONE |-> bad_va == $past(req_va));                     // R13

endmodule

// File: tb/test_vat_xlate.sv
module test_vat_xlate;
    import vat_pkg::*;

    localparam int DEPTH = 16;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  req_valid = 1'b0;
    logic [1:0]            req_kind = '0, req_size = '0, cur_plv = '0;
    logic [31:0]           req_va = '0;
    logic                  paging_on = 1'b0;
    logic [9:0]            cur_asid = '0;
    logic [1:0]            fetch_mat = 2'd2, data_mat = 2'd1;
    logic [9:0]            win0_cfg = 10'h205, win1_cfg = 10'h293;
    logic [DEPTH*84-1:0]   tlb_flat = '0;
    logic                  rsp_valid, pa_valid;
    logic [31:0]           pa, bad_va;
    logic [1:0]            pa_mat;
    logic [5:0]            exc_code;

    int tests = 0, fails = 0, cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vat_xlate #(.TLB_DEPTH(DEPTH)) i_vat_xlate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_size(req_size), .req_va(req_va), .cur_plv(cur_plv),
        .paging_on(paging_on), .cur_asid(cur_asid), .fetch_mat(fetch_mat),
        .data_mat(data_mat), .win0_cfg(win0_cfg), .win1_cfg(win1_cfg),
        .tlb_flat(tlb_flat), .rsp_valid(rsp_valid), .pa_valid(pa_valid),
        .pa(pa), .pa_mat(pa_mat), .exc_code(exc_code), .bad_va(bad_va)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [9:0]  asid;
        logic [1:0]  plv;
        logic        pg;
        logic [1:0]  kind;
        logic [1:0]  size;
        logic [31:0] va;
        logic [31:0] epa;
        logic [1:0]  emat;
        logic [5:0]  eec;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  10'd0, 2'd0, 1'b0, 2'd0, 2'd2, 32'h1234_5678, 32'h1234_5678, 2'd2, 6'd0},  // R3 fetch default
        '{4'd3,  10'd0, 2'd3, 1'b0, 2'd1, 2'd2, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 2'd1, 6'd0},  // R3 no bound
        '{4'd2,  10'd0, 2'd0, 1'b0, 2'd2, 2'd1, 32'h0000_1001, 32'h0,         2'd0, 6'd10}, // R2 half store
        '{4'd2,  10'd0, 2'd0, 1'b1, 2'd0, 2'd2, 32'h0000_2002, 32'h0,         2'd0, 6'd8},  // R2 fetch
        '{4'd2,  10'd0, 2'd0, 1'b0, 2'd1, 2'd0, 32'h0000_0003, 32'h0000_0003, 2'd1, 6'd0},  // R2 byte
        '{4'd4,  10'd0, 2'd0, 1'b1, 2'd1, 2'd0, 32'h8000_0003, 32'h0000_0003, 2'd1, 6'd0},  // R4 win0
        '{4'd5,  10'd0, 2'd3, 1'b1, 2'd1, 2'd2, 32'h8000_0010, 32'h0,         2'd0, 6'd9},  // R5 load
        '{4'd5,  10'd0, 2'd3, 1'b1, 2'd0, 2'd2, 32'h9000_0000, 32'h0,         2'd0, 6'd8},  // R5 fetch
        '{4'd4,  10'd0, 2'd3, 1'b1, 2'd2, 2'd2, 32'hA000_1234, 32'h2000_1234, 2'd0, 6'd0},  // R4 win1
        '{4'd7,  10'd5, 2'd3, 1'b1, 2'd1, 2'd2, 32'h0002_0044, 32'h00AB_C044, 2'd1, 6'd0},  // R7 even
        '{4'd10, 10'd5, 2'd3, 1'b1, 2'd1, 2'd2, 32'h0002_1008, 32'h0,         2'd0, 6'd7},  // R10
        '{4'd11, 10'd5, 2'd0, 1'b1, 2'd2, 2'd2, 32'h0002_1008, 32'h0,         2'd0, 6'd4},  // R11
        '{4'd11, 10'd5, 2'd3, 1'b1, 2'd2, 2'd2, 32'h0002_1008, 32'h0,         2'd0, 6'd7},  // R11 priv first
        '{4'd7,  10'd5, 2'd0, 1'b1, 2'd1, 2'd2, 32'h0002_1008, 32'h00DE_F008, 2'd2, 6'd0},  // R7 odd
        '{4'd12, 10'd7, 2'd0, 1'b1, 2'd1, 2'd2, 32'h0002_0100, 32'h7777_7100, 2'd0, 6'd0},  // R12 entry2 over 3
        '{4'd6,  10'd9, 2'd0, 1'b1, 2'd1, 2'd2, 32'h0002_0100, 32'h3333_3100, 2'd3, 6'd0},  // R6 global
        '{4'd8,  10'd5, 2'd0, 1'b1, 2'd1, 2'd2, 32'h0004_0000, 32'h0,         2'd0, 6'd63}, // R8 E=0
        '{4'd7,  10'd5, 2'd0, 1'b1, 2'd0, 2'd2, 32'h0041_2344, 32'h1221_2344, 2'd1, 6'd0},  // R7 large page
        '{4'd9,  10'd5, 2'd0, 1'b1, 2'd2, 2'd2, 32'h0060_0000, 32'h0,         2'd0, 6'd2},  // R9 store
        '{4'd9,  10'd5, 2'd0, 1'b1, 2'd0, 2'd2, 32'h0060_0000, 32'h0,         2'd0, 6'd3},  // R9 fetch
        '{4'd9,  10'd5, 2'd0, 1'b1, 2'd1, 2'd2, 32'h0060_0000, 32'h0,         2'd0, 6'd1},  // R9 load
        '{4'd6,  10'd3, 2'd3, 1'b1, 2'd2, 2'd2, 32'h0002_0000, 32'h3333_3000, 2'd3, 6'd0},  // R6 G=1
        '{4'd12, 10'd5, 2'd0, 1'b1, 2'd1, 2'd2, 32'h0002_0100, 32'h00AB_C100, 2'd1, 6'd0},  // R12 entry0
        '{4'd5,  10'd0, 2'd0, 1'b1, 2'd1, 2'd2, 32'hC000_0000, 32'h0,         2'd0, 6'd63}  // R5 level 0
    };

    function automatic half_t mk_half(logic v, logic d, logic [1:0] plv, logic [1:0] mat, logic [19:0] ppn);
        half_t h;
        h.v = v; h.d = d; h.plv = plv; h.mat = mat; h.ppn = ppn;
        return h;
    endfunction

    function automatic tlb_ent_t mk_ent(logic e, logic g, logic big, logic [9:0] asid,
                                        logic [18:0] vppn, half_t odd, half_t even);
        tlb_ent_t t;
        t.e = e; t.g = g; t.big = big; t.asid = asid; t.vppn = vppn;
        t.odd = odd; t.even = even;
        return t;
    endfunction

    task automatic check(string rq, logic [31:0] got, logic [31:0] exp, string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", rq, what, got, exp);
        end
    endtask

    task automatic run_vec(vec_t v);
        logic [73:0] got, exp;
        @(negedge clk);
        cur_asid = v.asid; cur_plv = v.plv; paging_on = v.pg;
        req_kind = v.kind; req_size = v.size; req_va = v.va; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got = {rsp_valid, pa_valid, pa, pa_mat, exc_code, bad_va};
        exp = {1'b1, (v.eec == 6'd0), v.epa, v.emat, v.eec, (v.eec == 6'd0) ? 32'h0 : v.va};
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d va=0x%08h: actual %h expected %h", v.rq, v.va, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tlb_flat[0*84 +: 84] = mk_ent(1, 0, 0, 10'd5, 19'h00010,
                                      mk_half(1, 0, 2'd0, 2'd2, 20'h00DEF),
                                      mk_half(1, 1, 2'd3, 2'd1, 20'h00ABC));
        tlb_flat[1*84 +: 84] = mk_ent(1, 1, 1, 10'd0, 19'h00200,
                                      mk_half(0, 0, 2'd0, 2'd0, 20'h0),
                                      mk_half(1, 1, 2'd3, 2'd1, 20'h12345));
        tlb_flat[2*84 +: 84] = mk_ent(1, 0, 0, 10'd7, 19'h00010,
                                      mk_half(0, 0, 2'd0, 2'd0, 20'h0),
                                      mk_half(1, 1, 2'd3, 2'd0, 20'h77777));
        tlb_flat[3*84 +: 84] = mk_ent(1, 1, 0, 10'd0, 19'h00010,
                                      mk_half(0, 0, 2'd0, 2'd0, 20'h0),
                                      mk_half(1, 1, 2'd3, 2'd3, 20'h33333));
        tlb_flat[4*84 +: 84] = mk_ent(0, 1, 0, 10'd5, 19'h00020,
                                      mk_half(1, 1, 2'd3, 2'd1, 20'h44444),
                                      mk_half(1, 1, 2'd3, 2'd1, 20'h44444));

        // R1 reset state, with a request held during reset
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {31'd0, rsp_valid}, 32'd0, "rsp_valid in reset");
        check("R13", {31'd0, pa_valid}, 32'd0, "pa_valid in reset");
        check("R13", {26'd0, exc_code}, 32'd0, "code in reset");
        req_valid = 1'b0;
        rst = 1'b0;

        // R1 idle cycle gives no response
        @(negedge clk);
        check("R1", {31'd0, rsp_valid}, 32'd0, "rsp_valid idle");

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1 response lasts a single cycle
        @(negedge clk);
        check("R1", {31'd0, rsp_valid}, 32'd0, "rsp_valid after response");

        // R4 window 0 beats window 1 when both cover segment 4 at level 0
        win1_cfg = 10'h233;
        run_vec('{4'd4, 10'd0, 2'd0, 1'b1, 2'd1, 2'd2, 32'h8000_0040, 32'h0000_0040, 2'd1, 6'd0});
        // R4 level 1 never hits a window, falls to the TLB and misses
        run_vec('{4'd4, 10'd0, 2'd1, 1'b1, 2'd1, 2'd2, 32'hA000_0040, 32'h0, 2'd0, 6'd63});
        win1_cfg = 10'h293;

        // R1 reset in the middle of a request clears the response
        @(negedge clk);
        req_valid = 1'b1; paging_on = 1'b0; req_va = 32'h10; req_size = 2'd2;
        rst = 1'b1;
        @(negedge clk);
        check("R1", {31'd0, rsp_valid}, 32'd0, "rsp_valid under reset");
        req_valid = 1'b0;
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule